// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block drives the command, clock-enable, address and bank pins of a four-bank single-data-rate SDRAM from reset until the memory is ready for normal use. It first holds the bus quiet with NOP commands for a start-up delay. It then closes every bank with one precharge, runs two auto-refresh cycles, and programs the mode register. Each command waits out the timing window that the previous one requires.

Every delay comes from parameters. The quiet time is given in microseconds and the row-precharge and refresh-cycle times in nanoseconds, and all of them are turned into clock counts using the clock frequency in MHz. The mode-register settover wait is a cycle count. The mode word is built from three parameters: burst length, burst order and CAS latency. When the sequence is over, `init_done_o` goes high and stays high. From then on the block holds NOP on the bus, so that a memory controller can take over.

Top module: `sdram_init_seq`

## Requirements
- R1: While rst_ni is low, the bus carries COMMAND INHIBIT ({cs_n,ras_n,cas_n,we_n} = 1111), cke_o is low, addr_o and ba_o are zero, and init_done_o is low.
- R2: cke_o is high from the first rising clock edge after reset is released, and stays high.
- R3: The first WAIT_CYC = WAIT_US*CLK_MHZ cycles after reset release carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111). No other command appears in that window.
- R4: The cycle after the quiet window carries PRECHARGE (0010) with address bit 10 set, all other address bits zero, and ba_o zero. This closes all banks.
- R5: The first AUTO REFRESH (0001) comes exactly RP_CYC cycles after the precharge, where RP_CYC = max(2, ceil(T_RP_NS*CLK_MHZ/1000)).
- R6: The second AUTO REFRESH comes exactly RC_CYC cycles after the first. LOAD MODE (0000) comes exactly RC_CYC cycles after the second. RC_CYC = max(2, ceil(T_RC_NS*CLK_MHZ/1000)).
- R7: LOAD MODE drives ba_o = 0 and an address word with the following fields. Bits 2:0 hold the burst length: 000, 001, 010 or 011 for 1, 2, 4 or 8, and 111 for full page (BURST_LEN = 0). Bit 3 is 1 for interleaved order. Bits 6:4 hold the CAS latency: 010 or 011. Every other bit is 0.
- R8: Only four non-NOP commands are issued, in the order precharge, refresh, refresh, load mode. Every cycle between them is NOP.
- R9: init_done_o rises exactly MRD_CYC = max(2, T_MRD_CYC) cycles after LOAD MODE. After that it stays high while the bus carries NOP with cke_o high.
- R10: If reset is asserted at any point in the sequence, the outputs return to the R1 state. The next release restarts the full sequence from the quiet window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Clock enable |
| addr_o | output | ADDR_W | Address bus (bit 10 selects all banks on precharge) |
| ba_o | output | BA_W | Bank address |
| init_done_o | output | 1 | Sequence complete |

## Verification
The hardest situation to reach is a reset that arrives in the middle of the sequence. A partial run leaves no trace on the pins once reset clears it, so only the following restart shows whether the block really went back to the quiet window. The stimulus releases reset and counts cycles until the first refresh has just gone out. It then asserts reset again, checks the R1 pin state, and requires a complete fresh sequence with full quiet-window spacing. A second instance built for 133 MHz runs alongside, with full-page burst, interleaved order and CAS latency 2. It exercises rounding up of the nanosecond delays and the other mode-word encodings.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_LMR = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111,
    CMD_INH = 4'b1111
  } cmd_e;

  typedef enum logic [2:0] {
    S_WAIT, S_PRE, S_TRP, S_REF, S_TRC, S_LMR, S_TMRD, S_DONE
  } seq_state_e;

  function automatic int cyc_of_ns(int ns, int mhz);
    int raw;
    raw = (ns * mhz + 999) / 1000;
    return (raw < 2) ? 2 : raw;
  endfunction

  function automatic logic [15:0] mode_word(int burst_len, bit interleave, int cas_lat);
    logic [15:0] w;
    w = '0;
    case (burst_len)
      1:       w[2:0] = 3'b000;
      2:       w[2:0] = 3'b001;
      4:       w[2:0] = 3'b010;
      8:       w[2:0] = 3'b011;
      default: w[2:0] = 3'b111;
    endcase
    w[3]   = interleave;
    w[6:4] = (cas_lat == 2) ? 3'b010 : 3'b011;
    return w;
  endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
  parameter int CNT_W   = 14,
  parameter int RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // an expired timer holds until reloaded, so a wait window cannot stretch by a wrap
  assert_timer_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && zero_o) |=> zero_o);

  assert_timer_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (zero_o == ($past(load_val_i) == '0)));

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
  import sdram_init_pkg::*;
#(
  parameter int CNT_W   = 14,
  parameter int RP_CYC  = 2,
  parameter int RC_CYC  = 7,
  parameter int MRD_CYC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output cmd_e             cmd_o,
  output logic             all_banks_o,
  output logic             mode_sel_o,
  output logic             done_o
);

  seq_state_e state_q, state_d;
  logic       second_q, second_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_WAIT;
      second_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      second_q <= second_d;
    end
  end

  always_comb begin
    state_d     = state_q;
    second_d    = second_q;
    load_o      = 1'b0;
    load_val_o  = '0;
    cmd_o       = CMD_NOP;
    all_banks_o = 1'b0;
    mode_sel_o  = 1'b0;
    done_o      = 1'b0;
    case (state_q)
      S_WAIT: if (zero_i) state_d = S_PRE;
      S_PRE: begin
        cmd_o       = CMD_PRE;
        all_banks_o = 1'b1;
        load_o      = 1'b1;
        load_val_o  = CNT_W'(RP_CYC - 2);
        state_d     = S_TRP;
      end
      S_TRP: if (zero_i) state_d = S_REF;
      S_REF: begin
        cmd_o      = CMD_REF;
        load_o     = 1'b1;
        load_val_o = CNT_W'(RC_CYC - 2);
        state_d    = S_TRC;
      end
      S_TRC: begin
        if (zero_i) begin
          if (second_q) state_d = S_LMR;
          else begin
            second_d = 1'b1;
            state_d  = S_REF;
          end
        end
      end
      S_LMR: begin
        cmd_o      = CMD_LMR;
        mode_sel_o = 1'b1;
        load_o     = 1'b1;
        load_val_o = CNT_W'(MRD_CYC - 2);
        state_d    = S_TMRD;
      end
      S_TMRD: if (zero_i) state_d = S_DONE;
      S_DONE: done_o = 1'b1;
      default: state_d = S_WAIT;
    endcase
  end

  assert_pre_after_wait_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_PRE) |-> ($past(state_q) == S_WAIT));

  assert_lmr_after_two_ref_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_LMR) |-> (second_q && $past(state_q) == S_TRC));

  assert_done_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DONE) |=> (state_q == S_DONE));

endmodule

// File: rtl/sdram_init_pins.sv
module sdram_init_pins
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BA_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_e              cmd_i,
  input  logic              all_banks_i,
  input  logic              mode_sel_i,
  input  logic              done_i,
  input  logic [ADDR_W-1:0] mode_word_i,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              cke_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              init_done_o
);

  localparam int AP_BIT = 10;

  cmd_e              cmd_q;
  logic              cke_q, done_q;
  logic [ADDR_W-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = '0;
    if (mode_sel_i)       addr_d = mode_word_i;
    else if (all_banks_i) addr_d[AP_BIT] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_INH;
      cke_q  <= 1'b0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      cmd_q  <= cmd_i;
      cke_q  <= 1'b1;
      addr_q <= addr_d;
      done_q <= done_i;
    end
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
  assign cke_o       = cke_q;
  assign addr_o      = addr_q;
  assign ba_o        = '0;
  assign init_done_o = done_q;

  assert_cke_with_cmd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q != CMD_INH) |-> cke_q);

  assert_pre_all_banks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q == CMD_PRE) |-> addr_q[AP_BIT]);

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (cmd_q == CMD_NOP && cke_q));

  assert_done_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> done_q);

  assert_no_back_to_back_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q inside {CMD_PRE, CMD_REF, CMD_LMR}) |=> (cmd_q == CMD_NOP));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int CLK_MHZ    = 100,
  parameter int WAIT_US    = 100,
  parameter int T_RP_NS    = 20,
  parameter int T_RC_NS    = 70,
  parameter int T_MRD_CYC  = 2,
  parameter int BURST_LEN  = 4,
  parameter bit INTERLEAVE = 1'b0,
  parameter int CAS_LAT    = 3,
  parameter int ADDR_W     = 11,
  parameter int BA_W       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic              cke_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BA_W-1:0]   ba_o,
  output logic              init_done_o
);

  localparam int WAIT_CYC = (WAIT_US * CLK_MHZ < 1) ? 1 : WAIT_US * CLK_MHZ;
  localparam int RP_CYC   = cyc_of_ns(T_RP_NS, CLK_MHZ);
  localparam int RC_CYC   = cyc_of_ns(T_RC_NS, CLK_MHZ);
  localparam int MRD_CYC  = (T_MRD_CYC < 2) ? 2 : T_MRD_CYC;
  localparam int MAX_CYC  = (WAIT_CYC > RC_CYC) ? WAIT_CYC : RC_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam logic [15:0] MODE_W16 = mode_word(BURST_LEN, INTERLEAVE, CAS_LAT);

  logic             load, zero, all_banks, mode_sel, done;
  logic [CNT_W-1:0] load_val;
  cmd_e             cmd;

  sdram_init_timer #(
    .CNT_W  (CNT_W),
    .RST_VAL(WAIT_CYC - 1)
  ) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(load_val),
    .zero_o    (zero)
  );

  sdram_init_fsm #(
    .CNT_W  (CNT_W),
    .RP_CYC (RP_CYC),
    .RC_CYC (RC_CYC),
    .MRD_CYC(MRD_CYC)
  ) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .zero_i     (zero),
    .load_o     (load),
    .load_val_o (load_val),
    .cmd_o      (cmd),
    .all_banks_o(all_banks),
    .mode_sel_o (mode_sel),
    .done_o     (done)
  );

  sdram_init_pins #(
    .ADDR_W(ADDR_W),
    .BA_W  (BA_W)
  ) i_pins (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .all_banks_i(all_banks),
    .mode_sel_i (mode_sel),
    .done_i     (done),
    .mode_word_i(MODE_W16[ADDR_W-1:0]),
    .cs_n_o     (cs_n_o),
    .ras_n_o    (ras_n_o),
    .cas_n_o    (cas_n_o),
    .we_n_o     (we_n_o),
    .cke_o      (cke_o),
    .addr_o     (addr_o),
    .ba_o       (ba_o),
    .init_done_o(init_done_o)
  );

endmodule

// File: tb/test_sdram_init_seq.sv
module test_sdram_init_seq;

  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001,
                         LMR = 4'b0000, INH = 4'b1111, DONE_EV = 4'hD;

  // configuration A: 100 MHz, 100 us, BL4 sequential, CL3
  localparam int A_WAIT = 100 * 100;
  localparam int A_RP   = 2;   // ceil(20*100/1000)
  localparam int A_RC   = 7;   // ceil(70*100/1000)
  localparam logic [10:0] A_MODE = 11'b000_0011_0_010;
  // configuration B: 133 MHz, 2 us, full page interleaved, CL2
  localparam int B_WAIT = 2 * 133;
  localparam int B_RP   = 3;   // ceil(2660/1000)
  localparam int B_RC   = 10;  // ceil(9310/1000)
  localparam logic [10:0] B_MODE = 11'b000_0010_1_111;
  localparam int MRD    = 2;

  typedef struct {
    logic [3:0]  cmd;
    logic [10:0] addr;
    bit          chk_addr;
    int          gap;
    string       req;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  int   checks = 0;
  int   errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        cs_a, ras_a, cas_a, we_a, cke_a, done_a;
  logic        cs_b, ras_b, cas_b, we_b, cke_b, done_b;
  logic [10:0] addr_a, addr_b;
  logic [1:0]  ba_a, ba_b;

  sdram_init_seq i_sdram_init_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .cs_n_o(cs_a), .ras_n_o(ras_a), .cas_n_o(cas_a), .we_n_o(we_a),
    .cke_o(cke_a), .addr_o(addr_a), .ba_o(ba_a), .init_done_o(done_a)
  );

  sdram_init_seq #(
    .CLK_MHZ(133), .WAIT_US(2), .BURST_LEN(0), .INTERLEAVE(1'b1), .CAS_LAT(2)
  ) i_sdram_init_seq_b (
    .clk_i(clk), .rst_ni(rst_n),
    .cs_n_o(cs_b), .ras_n_o(ras_b), .cas_n_o(cas_b), .we_n_o(we_b),
    .cke_o(cke_b), .addr_o(addr_b), .ba_o(ba_b), .init_done_o(done_b)
  );

  logic [3:0]  cmd_s  [2];
  logic [10:0] addr_s [2];
  logic [1:0]  ba_s   [2];
  logic        cke_s  [2];
  logic        done_s [2];
  assign cmd_s[0] = {cs_a, ras_a, cas_a, we_a};
  assign cmd_s[1] = {cs_b, ras_b, cas_b, we_b};
  assign addr_s[0] = addr_a;  assign addr_s[1] = addr_b;
  assign ba_s[0]   = ba_a;    assign ba_s[1]   = ba_b;
  assign cke_s[0]  = cke_a;   assign cke_s[1]  = cke_b;
  assign done_s[0] = done_a;  assign done_s[1] = done_b;

  exp_t exp_q [2][$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic push(int i, logic [3:0] c, logic [10:0] a, bit ca, int g, string r);
    exp_t e;
    e.cmd = c; e.addr = a; e.chk_addr = ca; e.gap = g; e.req = r;
    exp_q[i].push_back(e);
  endtask

  // driver side: the full expected command stream for one instance
  task automatic push_seq(int i, int wait_c, int rp, int rc, logic [10:0] mode);
    push(i, PRE, 11'h400, 1'b1, wait_c + 1, "R3/R4");
    push(i, REF, 11'h000, 1'b1, rp, "R5");
    push(i, REF, 11'h000, 1'b1, rc, "R6");
    push(i, LMR, mode, 1'b1, rc, "R6/R7");
    push(i, DONE_EV, 11'h000, 1'b0, MRD, "R9");
  endtask

  task automatic chk_reset_state(int i, string req);
    chk(cmd_s[i] == INH, req, "reset command", int'(cmd_s[i]), int'(INH));
    chk(cke_s[i] == 1'b0, req, "reset cke", int'(cke_s[i]), 0);
    chk(done_s[i] == 1'b0, req, "reset done", int'(done_s[i]), 0);
    chk(addr_s[i] == '0 && ba_s[i] == '0, req, "reset addr/ba",
        int'({ba_s[i], addr_s[i]}), 0);
  endtask

  // monitor: pops expected events as the design produces them
  int gap [2];
  bit prev_done [2];
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        gap[i] = 0;
        prev_done[i] = 1'b0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        logic [3:0] seen;
        bit is_ev;
        exp_t e;
        gap[i]++;
        is_ev = 1'b0;
        seen = cmd_s[i];
        if (done_s[i] && !prev_done[i]) begin
          seen = DONE_EV;
          is_ev = 1'b1;
        end else if (cmd_s[i] != NOP) begin
          is_ev = 1'b1;
        end
        if (!cke_s[i]) chk(1'b0, "R2", "cke low after reset", 0, 1);
        if (prev_done[i]) begin
          chk(done_s[i] && cmd_s[i] == NOP, "R9", "idle after done",
              int'({done_s[i], cmd_s[i]}), int'({1'b1, NOP}));
        end
        prev_done[i] = done_s[i];
        if (is_ev) begin
          if (exp_q[i].size() == 0) begin
            chk(1'b0, "R8", "unexpected command", int'(seen), int'(NOP));
          end else begin
            e = exp_q[i].pop_front();
            chk(seen == e.cmd, e.req, "command", int'(seen), int'(e.cmd));
            chk(gap[i] == e.gap, e.req, "cycles since previous event", gap[i], e.gap);
            if (e.chk_addr) begin
              chk(addr_s[i] == e.addr && ba_s[i] == '0, (e.cmd == LMR) ? "R7" : e.req,
                  "address/bank", int'({ba_s[i], addr_s[i]}), int'({2'b00, e.addr}));
            end
          end
          gap[i] = 0;
        end
      end
    end
  end

  task automatic wait_drain();
    while (exp_q[0].size() != 0 || exp_q[1].size() != 0) @(negedge clk);
  endtask

  task automatic tail_checks();
    repeat (20) @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      chk(done_s[i] == 1'b1, "R9", "done held", int'(done_s[i]), 1);
      chk(cke_s[i] == 1'b1, "R2", "cke held", int'(cke_s[i]), 1);
      chk(cmd_s[i] == NOP, "R8", "bus idle after sequence", int'(cmd_s[i]), int'(NOP));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_reset_state(0, "R1");
    chk_reset_state(1, "R1");

    // full run on both configurations
    push_seq(0, A_WAIT, A_RP, A_RC, A_MODE);
    push_seq(1, B_WAIT, B_RP, B_RC, B_MODE);
    @(negedge clk); #1 rst_n = 1'b1;
    wait_drain();
    tail_checks();

    // R10: reset after the first refresh of config A
    @(negedge clk); #1 rst_n = 1'b0;
    @(negedge clk);
    chk_reset_state(0, "R10");
    chk_reset_state(1, "R10");
    push(0, PRE, 11'h400, 1'b1, A_WAIT + 1, "R10");
    push(0, REF, 11'h000, 1'b1, A_RP, "R10");
    push_seq(1, B_WAIT, B_RP, B_RC, B_MODE);
    #1 rst_n = 1'b1;
    repeat (A_WAIT + 1 + A_RP + 3) @(negedge clk);
    chk(exp_q[0].size() == 0, "R10", "partial run progress", exp_q[0].size(), 0);
    #1 rst_n = 1'b0;
    @(negedge clk);
    chk_reset_state(0, "R10");
    chk_reset_state(1, "R10");
    exp_q[0].delete();
    exp_q[1].delete();

    // R10: restart must replay the whole sequence from the quiet window
    push_seq(0, A_WAIT, A_RP, A_RC, A_MODE);
    push_seq(1, B_WAIT, B_RP, B_RC, B_MODE);
    #1 rst_n = 1'b1;
    wait_drain();
    tail_checks();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule